// File: doc/BRIEF.md
# SPI Register-Access Slave

This block lets an external host read and write a bank of 8-bit control registers over a four-wire serial link. The wires are a serial clock, an active-low select, host-to-slave data and slave-to-host data. Each transaction opens when the select falls and closes when it rises. The host sends a command byte, then a register address byte, then any number of data bytes. Every byte travels most significant bit first.

A write command produces one register write strobe for each complete data byte. A read command streams the addressed register back on the output line. In both cases the register address steps up by one after each data byte, so one transaction covers consecutive registers. The register bank itself sits outside this block. The block drives the bank's address, write data and write enable, and takes the bank's read data back combinationally.

A parallel bus-side write port shares the bank write path. The serial side has priority. While the select is low, a bus write request is held off, and it is granted as soon as the select is high again.

All serial pins are brought into the system clock domain through short synchroniser chains. Serial edges are then detected as single-cycle events. The block is therefore meant for serial clock rates well below the system clock.

Top module: `spi_regbank_slave`

## Requirements
- R1: When the select line is high, `sdo` is 0 and the transaction state returns to expecting a command. A byte that is only partly shifted in when the select rises is dropped and causes no register write.
- R2: Data on `sdi` is sampled on the rising edge of `sck`, most significant bit first. Eight rising edges make one byte.
- R3: Command byte 0x80 selects streaming write. The next byte is the register address, and each following complete byte causes one single-cycle `regWrEn` pulse carrying that byte on `regWrData` and the current address on `regAddr`.
- R4: In streaming write, the address increments by one after each data byte and wraps from 0xFF to 0x00.
- R5: Command byte 0x40 selects streaming read. For each data byte, the addressed register value appears on `sdo` most significant bit first. The first bit is valid before the first rising `sck` edge of that byte, and later bits change after falling `sck` edges.
- R6: In streaming read, the address increments by one after each data byte, and the next byte returns the next register, wrapping from 0xFF to 0x00.
- R7: Any command byte other than 0x80 or 0x40 makes the rest of the transaction produce no register write and keep `sdo` at 0, until the select rises.
- R8: While the select is low, `busWrGrant` stays 0 and a held `busWrReq` causes no write. After the select rises, the pending bus write is granted and takes effect.
- R9: With the select high and no serial write pending, `busWrReq` is granted in the same cycle. `regWrEn` is 1, and `regAddr` and `regWrData` carry `busWrAddr` and `busWrData`.
- R10: A transaction with a single data byte, closed right after that byte, updates the addressed register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from host |
| csN | input | 1 | Active-low transaction select |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial data to host |
| regAddr | output | ADDR_W | Register bank address |
| regWrData | output | 8 | Register bank write data |
| regWrEn | output | 1 | Register bank write strobe |
| regRdData | input | 8 | Register bank read data for regAddr |
| busWrReq | input | 1 | Bus-side write request, held until granted |
| busWrAddr | input | ADDR_W | Bus-side write address |
| busWrData | input | 8 | Bus-side write data |
| busWrGrant | output | 1 | Bus-side write performed this cycle |

## Verification
The bench targets several corner cases, each tied to the wrong behaviour it would expose:
- Address wrap from 0xFF to 0x00 in both directions. A design with a wrong counter width or no wrap would write or return the wrong register.
- A trailing partial byte before the select rises. A design that keeps it would write a stray register.
- An unknown command followed by data. A design that decodes it would write registers or drive `sdo`.
- Streamed reads. A design that shifts on the falling edge that ends the previous byte would lose the top bit.
- A bus write raised in the middle of a serial transaction. A design without priority would grant it early.

Random write-then-read-back transactions of one to four bytes surround these directed cases.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] CMD_STREAM_WR = 8'h80;
  localparam logic [BYTE_W-1:0] CMD_STREAM_RD = 8'h40;

  typedef enum logic [1:0] {PH_CMD, PH_ADDR, PH_DATA, PH_SKIP} phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;      // select inactive: drop partial byte
    logic sampleBit;  // rising sck while selected
    logic shiftTx;    // advance output shifter
    logic loadTx;     // load output shifter from bank
    logic setAddr;    // take address byte
    logic incAddr;    // step address
    logic latchWr;    // capture write data byte
  } dpCtl_t;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sck,
  input  logic csN,
  input  logic sdi,
  output logic csActive,
  output logic sckRise,
  output logic sckFall,
  output logic sdiBit
);
  // bit 2 = csN, bit 1 = sck, bit 0 = sdi
  logic [2:0] chain [STAGES];
  logic sckPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= 3'b100;
      sckPrev <= 1'b0;
    end else begin
      chain[0] <= {csN, sck, sdi};
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      sckPrev <= chain[STAGES-1][1];
    end
  end

  assign csActive = ~chain[STAGES-1][2];
  assign sckRise  = chain[STAGES-1][1] & ~sckPrev;
  assign sckFall  = ~chain[STAGES-1][1] & sckPrev;
  assign sdiBit   = chain[STAGES-1][0];
endmodule

// File: rtl/spi_reg_dp.sv
module spi_reg_dp
  import spi_reg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic              sdiBit,
  input  logic [BYTE_W-1:0] rdData,
  output logic [BYTE_W-1:0] rxByte,
  output logic              lastBit,
  output logic              bitZero,
  output logic [ADDR_W-1:0] addr,
  output logic [BYTE_W-1:0] wrData,
  output logic              txBit
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] shiftIn;
  logic [BYTE_W-1:0] txShift;
  logic [CNT_W-1:0]  bitCnt;

  assign rxByte  = {shiftIn[BYTE_W-2:0], sdiBit};
  assign lastBit = (bitCnt == CNT_LAST);
  assign bitZero = (bitCnt == '0);
  assign txBit   = txShift[BYTE_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftIn <= '0;
      bitCnt  <= '0;
      txShift <= '0;
    end else if (ctl.clear) begin
      shiftIn <= '0;
      bitCnt  <= '0;
      txShift <= '0;
    end else begin
      if (ctl.sampleBit) begin
        shiftIn <= rxByte;
        bitCnt  <= bitCnt + 1'b1;
      end
      if (ctl.loadTx)       txShift <= rdData;
      else if (ctl.shiftTx) txShift <= {txShift[BYTE_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addr   <= '0;
      wrData <= '0;
    end else begin
      if (ctl.setAddr)      addr <= rxByte[ADDR_W-1:0];
      else if (ctl.incAddr) addr <= addr + 1'b1;
      if (ctl.latchWr)      wrData <= rxByte;
    end
  end

  // R2
  bit_count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.clear && !ctl.sampleBit) |=> bitCnt == $past(bitCnt));
endmodule

// File: rtl/spi_reg_ctl.sv
module spi_reg_ctl
  import spi_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              csActive,
  input  logic              sckRise,
  input  logic              sckFall,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              lastBit,
  input  logic              bitZero,
  output dpCtl_t            ctl,
  output logic              wrFire
);
  phase_e phase;
  logic   isRead;
  logic   loadPending;
  logic   byteDone;

  assign byteDone = csActive & sckRise & lastBit;

  always_comb begin
    ctl           = '0;
    ctl.clear     = ~csActive;
    ctl.sampleBit = csActive & sckRise;
    ctl.shiftTx   = csActive & sckFall & ~bitZero;
    ctl.loadTx    = loadPending;
    ctl.setAddr   = byteDone & (phase == PH_ADDR);
    ctl.incAddr   = wrFire | (byteDone & (phase == PH_DATA) & isRead);
    ctl.latchWr   = byteDone & (phase == PH_DATA) & ~isRead;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase       <= PH_CMD;
      isRead      <= 1'b0;
      loadPending <= 1'b0;
      wrFire      <= 1'b0;
    end else begin
      wrFire <= ctl.latchWr;
      if (!csActive) begin
        phase       <= PH_CMD;
        isRead      <= 1'b0;
        loadPending <= 1'b0;
      end else begin
        loadPending <= byteDone & isRead &
                       ((phase == PH_ADDR) | (phase == PH_DATA));
        if (byteDone) begin
          unique case (phase)
            PH_CMD: begin
              if (rxByte == CMD_STREAM_WR) begin
                isRead <= 1'b0;
                phase  <= PH_ADDR;
              end else if (rxByte == CMD_STREAM_RD) begin
                isRead <= 1'b1;
                phase  <= PH_ADDR;
              end else begin
                phase  <= PH_SKIP;
              end
            end
            PH_ADDR: phase <= PH_DATA;
            PH_DATA: phase <= PH_DATA;
            PH_SKIP: phase <= PH_SKIP;
          endcase
        end
      end
    end
  end

  // R1
  idle_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    !csActive |=> phase == PH_CMD);
  // R3
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrFire |=> !wrFire);
  // R7
  skip_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    phase == PH_SKIP |-> !ctl.latchWr && !ctl.loadTx);
  // R5
  load_read_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadPending |-> isRead);
endmodule

// File: rtl/spi_regbank_slave.sv
module spi_regbank_slave
  import spi_reg_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sck,
  input  logic              csN,
  input  logic              sdi,
  output logic              sdo,
  output logic [ADDR_W-1:0] regAddr,
  output logic [BYTE_W-1:0] regWrData,
  output logic              regWrEn,
  input  logic [BYTE_W-1:0] regRdData,
  input  logic              busWrReq,
  input  logic [ADDR_W-1:0] busWrAddr,
  input  logic [BYTE_W-1:0] busWrData,
  output logic              busWrGrant
);
  logic              csActive, sckRise, sckFall, sdiBit;
  logic [BYTE_W-1:0] rxByte, spiWrData;
  logic              lastBit, bitZero, txBit, wrFire;
  logic [ADDR_W-1:0] spiAddr;
  dpCtl_t            ctl;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rstN(rstN), .sck(sck), .csN(csN), .sdi(sdi),
    .csActive(csActive), .sckRise(sckRise), .sckFall(sckFall), .sdiBit(sdiBit)
  );

  spi_reg_ctl i_ctl (
    .clk(clk), .rstN(rstN), .csActive(csActive), .sckRise(sckRise),
    .sckFall(sckFall), .rxByte(rxByte), .lastBit(lastBit), .bitZero(bitZero),
    .ctl(ctl), .wrFire(wrFire)
  );

  spi_reg_dp #(.ADDR_W(ADDR_W)) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sdiBit(sdiBit), .rdData(regRdData),
    .rxByte(rxByte), .lastBit(lastBit), .bitZero(bitZero), .addr(spiAddr),
    .wrData(spiWrData), .txBit(txBit)
  );

  // serial side wins: bus only while deselected and no serial write in flight
  assign busWrGrant = busWrReq & ~csActive & ~wrFire;
  assign regWrEn    = wrFire | busWrGrant;
  assign regAddr    = busWrGrant ? busWrAddr : spiAddr;
  assign regWrData  = busWrGrant ? busWrData : spiWrData;
  assign sdo        = csActive & txBit;

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrFire |=> spiAddr == $past(spiAddr) + 1'b1);
  // R8
  bus_yield_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrFire |-> !busWrGrant && regAddr == spiAddr);
endmodule

// File: tb/test_spi_regbank_slave.sv
`timescale 1ns/1ps
module test_spi_regbank_slave;
  localparam int HALF = 6;

  logic       clk = 1'b0, rstN = 1'b0;
  logic       sck = 1'b0, csN = 1'b1, sdi = 1'b0;
  logic       sdo, regWrEn, busWrGrant;
  logic [7:0] regAddr, regWrData, regRdData;
  logic       busWrReq = 1'b0;
  logic [7:0] busWrAddr = '0, busWrData = '0;

  logic [7:0] bank   [256];
  logic [7:0] expMem [256];
  int checks = 0, fails = 0, wrCount = 0, grantCount = 0;
  bit watchSdo = 0, sdoSeen = 0, done = 0;

  always #5 clk = ~clk;

  spi_regbank_slave i_spi_regbank_slave (
    .clk(clk), .rstN(rstN), .sck(sck), .csN(csN), .sdi(sdi), .sdo(sdo),
    .regAddr(regAddr), .regWrData(regWrData), .regWrEn(regWrEn),
    .regRdData(regRdData), .busWrReq(busWrReq), .busWrAddr(busWrAddr),
    .busWrData(busWrData), .busWrGrant(busWrGrant)
  );

  assign regRdData = bank[regAddr];

  always @(posedge clk) begin
    if (regWrEn) begin
      bank[regAddr] <= regWrData;
      wrCount++;
    end
    if (busWrGrant) grantCount++;
    if (watchSdo && sdo) sdoSeen = 1;
  end

  function automatic logic [7:0] stepAddr(input logic [7:0] a, input int k);
    return 8'(a + k);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic selOpen();
    @(negedge clk); csN = 1'b0; waitClk(HALF);
  endtask

  task automatic selClose();
    waitClk(HALF); csN = 1'b1; sdi = 1'b0; waitClk(4 * HALF);
  endtask

  task automatic xferBits(input logic [7:0] tx, input int nBits, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - nBits; i--) begin
      @(negedge clk); sdi = tx[i];
      waitClk(HALF);
      rx[i] = sdo; sck = 1'b1;
      waitClk(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic spiWrite(input logic [7:0] a, input int n, input logic [7:0] d [4]);
    logic [7:0] junk;
    selOpen();
    xferBits(8'h80, 8, junk);
    xferBits(a, 8, junk);
    for (int k = 0; k < n; k++) begin
      xferBits(d[k], 8, junk);
      expMem[stepAddr(a, k)] = d[k];
    end
    selClose();
  endtask

  task automatic spiRead(input logic [7:0] a, input int n, output logic [7:0] q [4]);
    logic [7:0] junk;
    selOpen();
    xferBits(8'h40, 8, junk);
    xferBits(a, 8, junk);
    for (int k = 0; k < n; k++) xferBits(8'($urandom), 8, q[k]);
    selClose();
  endtask

  initial begin
    logic [7:0] d [4];
    logic [7:0] q [4];
    logic [7:0] junk;
    int w0;
    void'($urandom(32'h5EED1234));
    for (int i = 0; i < 256; i++) begin
      bank[i] = 8'(i) ^ 8'hA5;
      expMem[i] = 8'(i) ^ 8'hA5;
    end
    waitClk(4);
    rstN = 1'b1;
    waitClk(4);
    // R1 reset state
    check(sdo == 0 && regWrEn == 0 && busWrGrant == 0, "R1 reset", {sdo, regWrEn, busWrGrant}, 0);

    // R10 single byte then close
    d[0] = 8'h5A;
    spiWrite(8'h13, 1, d);
    check(bank[8'h13] == 8'h5A, "R10 single byte", bank[8'h13], 8'h5A);

    // R4 write wrap
    d = '{8'h11, 8'h22, 8'h33, 8'h00};
    spiWrite(8'hFE, 3, d);
    check(bank[8'hFE] == 8'h11 && bank[8'hFF] == 8'h22 && bank[8'h00] == 8'h33,
          "R4 write wrap", {bank[8'hFE], bank[8'hFF], bank[8'h00]}, 24'h112233);

    // R5/R6 read wrap
    spiRead(8'hFE, 4, q);
    check(q[0] == 8'h11, "R5 first read", q[0], 8'h11);
    check(q[1] == 8'h22 && q[2] == 8'h33, "R6 read wrap", {q[1], q[2]}, 16'h2233);
    check(q[3] == expMem[8'h01], "R6 read step", q[3], expMem[8'h01]);
    // R1 sdo low after close
    check(sdo == 1'b0, "R1 sdo idle", sdo, 0);

    // R7 unknown command
    w0 = wrCount; sdoSeen = 0; watchSdo = 1;
    selOpen();
    xferBits(8'h3C, 8, junk);
    xferBits(8'h20, 8, junk);
    xferBits(8'hFF, 8, junk);
    xferBits(8'hFF, 8, junk);
    selClose();
    watchSdo = 0;
    check(wrCount == w0, "R7 no write", wrCount - w0, 0);
    check(!sdoSeen, "R7 sdo quiet", sdoSeen, 0);
    d[0] = 8'hC3;
    spiWrite(8'h20, 1, d);
    check(bank[8'h20] == 8'hC3, "R7 recovers", bank[8'h20], 8'hC3);

    // R1 partial byte dropped
    selOpen();
    xferBits(8'h80, 8, junk);
    xferBits(8'h30, 8, junk);
    xferBits(8'h9E, 8, junk);
    xferBits(8'hFF, 3, junk);
    selClose();
    expMem[8'h30] = 8'h9E;
    check(bank[8'h30] == 8'h9E, "R1 full byte kept", bank[8'h30], 8'h9E);
    check(bank[8'h31] == expMem[8'h31], "R1 partial dropped", bank[8'h31], expMem[8'h31]);
    spiRead(8'h30, 2, q);
    check(q[0] == 8'h9E && q[1] == expMem[8'h31], "R1 state reset", {q[0], q[1]}, {8'h9E, expMem[8'h31]});

    // R8 bus held during select
    selOpen();
    xferBits(8'h80, 8, junk);
    @(negedge clk);
    busWrReq = 1'b1; busWrAddr = 8'h44; busWrData = 8'h77;
    w0 = grantCount;
    xferBits(8'h45, 8, junk);
    xferBits(8'h66, 8, junk);
    check(grantCount == w0 && bank[8'h44] == expMem[8'h44], "R8 held", grantCount - w0, 0);
    waitClk(HALF); csN = 1'b1; sdi = 1'b0;
    for (int t = 0; t < 40 && !busWrGrant; t++) @(negedge clk);
    check(busWrGrant == 1'b1, "R8 granted after close", busWrGrant, 1);
    @(negedge clk); busWrReq = 1'b0;
    expMem[8'h44] = 8'h77; expMem[8'h45] = 8'h66;
    check(bank[8'h44] == 8'h77 && bank[8'h45] == 8'h66, "R8 both writes",
          {bank[8'h44], bank[8'h45]}, 16'h7766);

    // R9 idle bus write same cycle
    waitClk(4);
    busWrReq = 1'b1; busWrAddr = 8'h9A; busWrData = 8'hE1;
    #1;
    check(busWrGrant && regWrEn && regAddr == 8'h9A && regWrData == 8'hE1,
          "R9 idle grant", {busWrGrant, regWrEn, regAddr, regWrData}, {2'b11, 16'h9AE1});
    @(negedge clk); busWrReq = 1'b0;
    expMem[8'h9A] = 8'hE1;
    check(bank[8'h9A] == 8'hE1, "R9 written", bank[8'h9A], 8'hE1);

    // R2 R3 R5 R6 random write then read back
    for (int n = 0; n < 25; n++) begin
      logic [7:0] a;
      int len;
      a = 8'($urandom);
      len = 1 + int'($urandom % 4);
      for (int k = 0; k < 4; k++) d[k] = 8'($urandom);
      spiWrite(a, len, d);
      spiRead(a, len, q);
      for (int k = 0; k < len; k++)
        check(q[k] == expMem[stepAddr(a, k)] && bank[stepAddr(a, k)] == expMem[stepAddr(a, k)],
              "R2/R3 random readback", q[k], expMem[stepAddr(a, k)]);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule